// File: doc/BRIEF.md
# Burst-four DDR write port

This block is the device-side write path of a quad-data-rate style synchronous memory that moves four words per write command. A write command is sampled on the rising edge of the clock together with a burst address. One clock later the four data words of that burst arrive on four successive clock edges: rising, falling, rising, falling. Each word lands in its own location of an internal array, and each 9-bit lane of each word can be masked on its own.

Commands can be issued every second rising edge. In that case data flows on every edge of the clock with no gap. A command on the rising edge right after an accepted one is dropped. Beats captured on a falling edge are held in a small register and committed on the following rising edge, so the array is written only on rising edges, through two write ports. A combinational lookup port exposes any array word so that a neighbouring read path, or a test bench, can see what was stored.

Top module: `bdw_write_port`

## Requirements
- R1: A command is accepted at a rising edge when `wr_n` is 0, `rst` is 0, and no command was accepted at the previous rising edge. `wr_addr` is latched at that edge. The word address of beat k is `{wr_addr, k}`, with k a 2-bit index in the low bits.
- R2: Beat 0 is taken from `wr_data` at the first rising edge after acceptance and written to word `{A,0}`. It shows on the lookup port immediately after that edge.
- R3: Beats 1, 2 and 3 are taken at the following falling, rising and falling edges and go to words `{A,1}`, `{A,2}` and `{A,3}`. A beat taken on a falling edge reaches the array at the next rising edge.
- R4: A command that arrives one rising edge after an accepted command is ignored. A command that arrives two rising edges after it is accepted, so that data is captured on every edge of the clock.
- R5: Data and strobes driven on an edge where no beat is due leave the array unchanged.
- R6: For each beat, `wr_bw_n[i]` = 0 writes bits 9i to 9i+8 of the word and `wr_bw_n[i]` = 1 keeps the stored bits. The strobes are sampled with each beat, so each beat can use its own mask. The number of lanes is DATA_W/9, with DATA_W equal to 18 or 36.
- R7: Once a command is accepted, all four of its beats are written whatever `wr_n` does afterwards.
- R8: When `rst` is 1 at a rising edge, no command is accepted at that edge. Its effect on pending beats:
  - the beat due at that edge is dropped;
  - a falling-edge beat that is waiting to be written is dropped;
  - all remaining beats are dropped;
  - array contents are kept.
- R9: `peek_data` always equals the array word at `peek_addr`, without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges carry data beats |
| rst | input | 1 | Synchronous active-high reset of the burst state |
| wr_n | input | 1 | Active-low write command, sampled on the rising edge |
| wr_addr | input | ADDR_W | Burst address, latched with the command |
| wr_data | input | DATA_W | Data beat bus, sampled on both edges |
| wr_bw_n | input | DATA_W/9 | Active-low lane write strobes, one per 9-bit lane |
| peek_addr | input | ADDR_W+2 | Word address for the lookup port |
| peek_data | output | DATA_W | Array word at `peek_addr` |

## Verification
The assertions assume reset is held for at least three rising edges at start-up, so that the command history they look back over is clean. They also assume the inputs are steady around both clock edges, since half of the beats are taken on the falling edge. The bench holds reset for four cycles and changes every input 1 ns after an edge. It raises or lowers reset only at those points, which keeps each input steady across the edge that samples it. Stimulus mixes the following with random data, strobes and addresses from a fixed seed, and is judged against a bench model of the array:
- directed single bursts;
- streamed bursts at spacings of two, four and eight half-cycle slots;
- a reset in the middle of a burst.

// File: rtl/bdw_pkg.sv
`timescale 1ns/1ps
package bdw_pkg;
  // width of one strobe-controlled lane
  localparam int unsigned LANE_W = 9;
  // words per command
  localparam int unsigned BEATS  = 4;
  localparam int unsigned BEAT_W = $clog2(BEATS);

  typedef logic [BEAT_W-1:0] beat_t;

  // beat order within a burst: rise, fall, rise, fall
  localparam beat_t BEAT_R0 = 2'd0;
  localparam beat_t BEAT_F1 = 2'd1;
  localparam beat_t BEAT_R2 = 2'd2;
  localparam beat_t BEAT_F3 = 2'd3;

  function automatic int unsigned lanes_of(input int unsigned width);
    return width / LANE_W;
  endfunction
endpackage

// File: rtl/bdw_cmd_seq.sv
`timescale 1ns/1ps
module bdw_cmd_seq
  import bdw_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_n,
  input  logic [ADDR_W-1:0]        wr_addr,
  output logic                     cmd_acc,
  output logic                     rise_we,
  output logic [ADDR_W+BEAT_W-1:0] rise_waddr,
  output logic                     fall_arm,
  output logic [ADDR_W+BEAT_W-1:0] fall_aaddr
);
  localparam int unsigned WA_W = ADDR_W + BEAT_W;

  function automatic logic [WA_W-1:0] word_of(input logic [ADDR_W-1:0] base,
                                              input beat_t k);
    return {base, k};
  endfunction

  // pend: beat 0 due at this rising edge
  // lo:   beats 1 (fall) and 2 (rise) due
  // hi:   beat 3 (fall) due
  logic              pend_q, lo_q, hi_q;
  logic [ADDR_W-1:0] pend_addr_q, lo_addr_q, hi_addr_q;

  assign cmd_acc = !rst && !wr_n && !pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      lo_q   <= 1'b0;
      hi_q   <= 1'b0;
    end else begin
      pend_q <= cmd_acc;
      lo_q   <= pend_q;
      hi_q   <= lo_q;
    end
    if (cmd_acc) pend_addr_q <= wr_addr;
    if (pend_q)  lo_addr_q   <= pend_addr_q;
    if (lo_q)    hi_addr_q   <= lo_addr_q;
  end

  assign rise_we    = !rst && (pend_q || lo_q);
  assign rise_waddr = pend_q ? word_of(pend_addr_q, BEAT_R0)
                             : word_of(lo_addr_q, BEAT_R2);
  assign fall_arm   = lo_q || hi_q;
  assign fall_aaddr = lo_q ? word_of(lo_addr_q, BEAT_F1)
                           : word_of(hi_addr_q, BEAT_F3);

  AST_THIRD_BEAT_RISE: assert property (@(posedge clk) disable iff (rst)
    cmd_acc |-> ##2 (rise_we && rise_waddr[BEAT_W-1:0] == BEAT_R2)); // R3
endmodule

// File: rtl/bdw_fall_cap.sv
`timescale 1ns/1ps
module bdw_fall_cap #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned LANES  = 4,
  parameter int unsigned WA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [WA_W-1:0]   arm_addr,
  input  logic [DATA_W-1:0] din,
  input  logic [LANES-1:0]  bw_n,
  output logic              fall_we,
  output logic [WA_W-1:0]   fall_waddr,
  output logic [DATA_W-1:0] fall_d,
  output logic [LANES-1:0]  fall_bw_n
);
  logic held_q;

  // capture on the inverted clock, commit at the next rising edge
  always_ff @(negedge clk) begin
    if (rst) held_q <= 1'b0;
    else     held_q <= arm;
    if (arm) begin
      fall_waddr <= arm_addr;
      fall_d     <= din;
      fall_bw_n  <= bw_n;
    end
  end

  assign fall_we = held_q && !rst;
endmodule

// File: rtl/bdw_array.sv
`timescale 1ns/1ps
module bdw_array
  import bdw_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned LANES  = 4,
  parameter int unsigned WA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wa_we,
  input  logic [WA_W-1:0]   wa_addr,
  input  logic [DATA_W-1:0] wa_d,
  input  logic [LANES-1:0]  wa_bw_n,
  input  logic              wb_we,
  input  logic [WA_W-1:0]   wb_addr,
  input  logic [DATA_W-1:0] wb_d,
  input  logic [LANES-1:0]  wb_bw_n,
  input  logic [WA_W-1:0]   peek_addr,
  output logic [DATA_W-1:0] peek_data
);
  localparam int unsigned DEPTH = 1 << WA_W;

  function automatic logic [LANE_W-1:0] lane_slice(input logic [DATA_W-1:0] w,
                                                   input int unsigned ln);
    return w[ln*LANE_W +: LANE_W];
  endfunction

  // one storage column per lane; each lane has its own write enables
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [LANE_W-1:0] col [DEPTH];
    logic              a_hit, b_hit;
    assign a_hit = wa_we && !wa_bw_n[ln];
    assign b_hit = wb_we && !wb_bw_n[ln];
    always_ff @(posedge clk) begin
      if (a_hit) col[wa_addr] <= lane_slice(wa_d, ln);
      if (b_hit) col[wb_addr] <= lane_slice(wb_d, ln);
    end
    assign peek_data[ln*LANE_W +: LANE_W] = col[peek_addr];
  end

  AST_PORTS_DISJOINT: assert property (@(posedge clk) disable iff (rst)
    (wa_we && wb_we) |-> (wa_addr != wb_addr)); // R3
endmodule

// File: rtl/bdw_write_port.sv
`timescale 1ns/1ps
module bdw_write_port
  import bdw_pkg::*;
#(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_n,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [DATA_W/9-1:0]      wr_bw_n,
  input  logic [ADDR_W+BEAT_W-1:0] peek_addr,
  output logic [DATA_W-1:0]        peek_data
);
  localparam int unsigned LANES = lanes_of(DATA_W);
  localparam int unsigned WA_W  = ADDR_W + BEAT_W;

  logic            cmd_acc;
  logic            rise_we, fall_arm, fall_we;
  logic [WA_W-1:0] rise_waddr, fall_aaddr, fall_waddr;
  logic [DATA_W-1:0] fall_d;
  logic [LANES-1:0]  fall_bw_n;

  bdw_cmd_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk        (clk),
    .rst        (rst),
    .wr_n       (wr_n),
    .wr_addr    (wr_addr),
    .cmd_acc    (cmd_acc),
    .rise_we    (rise_we),
    .rise_waddr (rise_waddr),
    .fall_arm   (fall_arm),
    .fall_aaddr (fall_aaddr)
  );

  bdw_fall_cap #(.DATA_W(DATA_W), .LANES(LANES), .WA_W(WA_W)) fcap_i (
    .clk        (clk),
    .rst        (rst),
    .arm        (fall_arm),
    .arm_addr   (fall_aaddr),
    .din        (wr_data),
    .bw_n       (wr_bw_n),
    .fall_we    (fall_we),
    .fall_waddr (fall_waddr),
    .fall_d     (fall_d),
    .fall_bw_n  (fall_bw_n)
  );

  bdw_array #(.DATA_W(DATA_W), .LANES(LANES), .WA_W(WA_W)) arr_i (
    .clk       (clk),
    .rst       (rst),
    .wa_we     (rise_we),
    .wa_addr   (rise_waddr),
    .wa_d      (wr_data),
    .wa_bw_n   (wr_bw_n),
    .wb_we     (fall_we),
    .wb_addr   (fall_waddr),
    .wb_d      (fall_d),
    .wb_bw_n   (fall_bw_n),
    .peek_addr (peek_addr),
    .peek_data (peek_data)
  );

  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (rst)
    cmd_acc |=> (rise_we && rise_waddr == {$past(wr_addr), BEAT_R0})); // R2

  AST_FALL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (rise_we && rise_waddr[BEAT_W-1:0] == BEAT_R0)
      |=> (fall_we && fall_waddr == $past(rise_waddr) + WA_W'(1))); // R3

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(cmd_acc) && !$past(cmd_acc, 2) && !$past(cmd_acc, 3))
      |-> (!rise_we && !fall_we)); // R5

  AST_RESET_DROPS: assert property (@(posedge clk)
    rst |=> (!rise_we && !fall_we)); // R8
endmodule

// File: tb/bdw_write_port_tb.sv
`timescale 1ns/1ps
module bdw_write_port_tb_top;
  localparam int DW  = 36;
  localparam int AW  = 6;
  localparam int LN  = DW / 9;
  localparam int WAW = AW + 2;
  localparam int NW  = 1 << WAW;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_n = 1'b1;
  logic [AW-1:0]  wr_addr = '0;
  logic [DW-1:0]  wr_data = '0;
  logic [LN-1:0]  wr_bw_n = '1;
  logic [WAW-1:0] peek_addr = '0;
  logic [DW-1:0]  peek_data;

  always #10 clk = ~clk;  // 50 MHz

  bdw_write_port #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .wr_n(wr_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_bw_n(wr_bw_n), .peek_addr(peek_addr), .peek_data(peek_data)
  );

  // reference model state
  logic [DW-1:0] ref_mem [NW];
  int n_chk = 0;
  int n_err = 0;
  int slot_n = 0;      // even slot ends on a rising edge
  bit cur_v, prv_v;
  int cur_s, prv_s;
  logic [AW-1:0] cur_a, prv_a;
  bit fp_v;
  logic [WAW-1:0] fp_a;
  logic [DW-1:0]  fp_d;
  logic [LN-1:0]  fp_bw;

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w,
                                               input logic [LN-1:0] bw);
    logic [DW-1:0] r;
    for (int b = 0; b < DW; b++) r[b] = bw[b / 9] ? old_w[b] : new_w[b];
    return r;
  endfunction

  function automatic bit beat_due(input int t, output logic [WAW-1:0] wa);
    int k;
    wa = '0;
    k = t - cur_s - 2;
    if (cur_v && k >= 0 && k <= 3) begin wa = {cur_a, 2'(k)}; return 1'b1; end
    k = t - prv_s - 2;
    if (prv_v && k >= 0 && k <= 3) begin wa = {prv_a, 2'(k)}; return 1'b1; end
    return 1'b0;
  endfunction

  function automatic logic [DW-1:0] rand_data();
    return DW'({$urandom(), $urandom()});
  endfunction

  function automatic logic [LN-1:0] rand_bw();
    return ($urandom % 3 == 0) ? '0 : LN'($urandom);
  endfunction

  task automatic slot(input logic wn, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [LN-1:0] bw, input logic [WAW-1:0] pa,
                      input bit chk, input string tag);
    logic [WAW-1:0] ta;
    wr_n = wn; wr_addr = a; wr_data = d; wr_bw_n = bw; peek_addr = pa;
    #8;
    if (chk && !$isunknown(ref_mem[pa])) begin
      n_chk++;
      if (peek_data !== ref_mem[pa]) begin
        n_err++;
        $display("FAIL %s word %0d: got %h expected %h", tag, pa, peek_data, ref_mem[pa]);
      end
    end
    if (slot_n % 2 == 0) begin
      if (rst) begin
        fp_v = 0; cur_v = 0; prv_v = 0;
      end else begin
        if (fp_v) begin ref_mem[fp_a] = lane_merge(ref_mem[fp_a], fp_d, fp_bw); fp_v = 0; end
        if (beat_due(slot_n, ta)) ref_mem[ta] = lane_merge(ref_mem[ta], d, bw);
        if (!wn && !(cur_v && cur_s == slot_n - 2)) begin
          prv_v = cur_v; prv_s = cur_s; prv_a = cur_a;
          cur_v = 1; cur_s = slot_n; cur_a = a;
        end
      end
    end else begin
      fp_v = 0;
      if (!rst && beat_due(slot_n, ta)) begin
        fp_v = 1; fp_a = ta; fp_d = d; fp_bw = bw;
      end
    end
    #2;
    slot_n++;
  endtask

  task automatic to_rise();
    if (slot_n % 2 != 0) slot(1'b1, '0, rand_data(), rand_bw(), '0, 1'b0, "");
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++)
      slot(1'b1, AW'($urandom), rand_data(), rand_bw(), WAW'($urandom), 1'b1, tag);
  endtask

  task automatic sweep(input int lo, input int hi, input string tag);
    for (int w = lo; w <= hi; w++)
      slot(1'b1, AW'($urandom), rand_data(), rand_bw(), WAW'(w), 1'b1, tag);
  endtask

  // n commands, one every gap slots (gap even)
  task automatic stream(input int n, input int gap, input int base, input bit masked,
                        input string tag);
    to_rise();
    for (int i = 0; i < n * gap + 6; i++) begin
      logic wn;
      wn = !((i % gap) == 0 && (i / gap) < n);
      slot(wn, AW'(base + i / gap), rand_data(), masked ? rand_bw() : '0,
           {AW'(base + int'($urandom % n)), 2'($urandom % 4)}, 1'b1, tag);
    end
  endtask

  // one burst, lookup port follows the words as they are written
  task automatic single(input logic [AW-1:0] a, input string tag);
    int pl [10] = '{0, 0, 0, 0, 1, 1, 3, 3, 2, 0};
    to_rise();
    for (int i = 0; i < 10; i++)
      slot((i == 0) ? 1'b0 : 1'b1, a, rand_data(), '0, {a, 2'(pl[i])}, 1'b1, tag);
  endtask

  task automatic run_all();
    void'($urandom(32'h5eed_2024));
    for (int w = 0; w < NW; w++) ref_mem[w] = 'x;
    idle(8, "R8");
    rst = 1'b0;
    stream(NW / 4, 4, 0, 1'b0, "R4");        // fill, gapless data
    idle(8, "R4");
    sweep(0, NW - 1, "R5/R9");               // bus toggles, no command
    single(6'd5, "R1/R2/R3");
    single(6'd9, "R1/R2/R3");
    stream(8, 2, 12, 1'b0, "R4");            // every-edge commands
    sweep(48, 95, "R4");
    stream(10, 4, 24, 1'b1, "R6");           // per-beat masks
    sweep(96, 139, "R6");
    stream(6, 8, 40, 1'b1, "R7");            // wr_n high during beats
    sweep(160, 187, "R7");
    // reset in the middle of a burst, commands during reset
    to_rise();
    slot(1'b0, 6'd20, rand_data(), '0, {6'd20, 2'd0}, 1'b1, "R8");
    slot(1'b1, 6'd20, rand_data(), '0, {6'd20, 2'd0}, 1'b1, "R8");
    slot(1'b1, 6'd20, rand_data(), '0, {6'd20, 2'd0}, 1'b1, "R8");
    rst = 1'b1;
    slot(1'b0, 6'd21, rand_data(), '0, {6'd20, 2'd0}, 1'b1, "R8");
    slot(1'b0, 6'd22, rand_data(), '0, {6'd20, 2'd1}, 1'b1, "R8");
    slot(1'b1, 6'd22, rand_data(), '0, {6'd20, 2'd2}, 1'b1, "R8");
    rst = 1'b0;
    idle(6, "R8");
    sweep(80, 91, "R8");
    // random mix on a small address window
    to_rise();
    for (int i = 0; i < 4000; i++) begin
      logic wn;
      wn = !((i % 2 == 0) && ($urandom % 2 == 0));
      slot(wn, AW'($urandom % 8), rand_data(), rand_bw(),
           {AW'($urandom % 8), 2'($urandom % 4)}, 1'b1, "R1/R6");
    end
    idle(8, "R7");
    sweep(0, NW - 1, "R9");
  endtask

  initial begin
    #1;
    fork
      run_all();
      begin
        #2_000_000;
        n_err++;
        $display("FAIL R7 watchdog: got timeout expected run completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule